// File: doc/BRIEF.md
# Dual-Clock Strobed FIFO with Programmable Watermark Flag

This block is a first-in first-out buffer of 256 words of 18 bits. Words are written on cycles of a load clock and removed on cycles of an unload clock. The two clocks may be unrelated, or they may be the same net. Write and read pointers cross between the two domains as Gray code through a short synchronizer chain. Each status flag is computed in the domain whose own action can set it. A flag therefore sets on the same edge that causes it, and may clear a few cycles late.

The read side works in fall-through mode. The oldest stored word is held on `q` as soon as it becomes visible, and each unload strobe moves on to the next word. Two status flags are active low: `full_n` and `empty_n`. There is also a half-full flag and a single watermark flag, `almost`. The watermark flag covers two cases: a low-occupancy limit X and a high-occupancy limit of DEPTH−Y. Both offsets default to 32. Right after reset they can be loaded from `din[6:0]` with one or two load strobes while `prog_n` is low. Once that window has closed, it stays closed until the next reset.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds at most 256 words. `full_n` goes low on the load edge that stores the 256th unread word, and stays high at every lower occupancy.
- R2: A load strobe while `full_n` is low stores nothing. An unload strobe while `empty_n` is low has no effect on the pointers or on the data later returned.
- R3: `empty_n` is low exactly when no unread word is held. The first word written into an empty buffer appears on `q` and raises `empty_n` with no unload strobe. Each unload strobe presents the next word, in write order.
- R4: `half_full` is high whenever 128 or more words are held.
- R5: `almost` is high when occupancy is at most X or at least 256−Y, and low from X+1 through 255−Y.
- R6: Reset is synchronous and active-high, held for at least 4 cycles of each clock. After reset, `full_n`=1, `empty_n`=0, `half_full`=0 and `almost`=1.
- R7: If `prog_n` stays high after reset, X = Y = 32.
- R8: The first load strobe after reset with `prog_n` low loads `din[6:0]` into both X and Y. A second consecutive load strobe with `prog_n` low reloads only Y from `din[6:0]`. Each offset is 7 bits wide, so at most 127.
- R9: A load strobe used for offset programming writes no word into the buffer.
- R10: The programming window closes at the first load strobe with `prog_n` high, or after the second programming strobe. After it closes, a load strobe with `prog_n` low is an ordinary write.
- R11: With `oe_n` high, `q` is high impedance. With `oe_n` low, `q` carries the head word, not inverted.
- R12: Pointer-crossing delay only ever delays the release of a flag. `full_n`, `half_full` and the high-occupancy part of `almost` set on the load edge that reaches them. `empty_n` and the low-occupancy part of `almost` set on the unload edge that reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ld | input | 1 | Load-side clock |
| clk_ul | input | 1 | Unload-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| ld_en | input | 1 | Load strobe, sampled on `clk_ld` |
| din | input | 18 | Write data; bits 6..0 also carry offset values |
| prog_n | input | 1 | Low selects offset programming during the window |
| ul_en | input | 1 | Unload strobe, sampled on `clk_ul` |
| oe_n | input | 1 | High places `q` in high impedance |
| q | output | 18 | Head word of the buffer |
| full_n | output | 1 | Low when 256 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High at 128 or more words |
| almost | output | 1 | High near empty (≤X) or near full (≥256−Y) |

## Verification
The bench keeps the default parameters: an 8-bit address for 256 words, 18-bit data, 7-bit offsets defaulting to 32, and a two-stage synchronizer. With a single 125 MHz clock driving both sides, a complete fill to 256 words and a drain back to empty take only a few hundred cycles. Every flag boundary can therefore be reached directly: 32/33 and 223/224 for the defaults, 127/128 for half-full, and 5/6 and 245/246 for programmed offsets. Driving both domains from one clock also lets the bench count the exact edge on which `full_n` and `empty_n` set.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Offset-programming window after reset
  typedef enum logic [1:0] {
    PRG_OPEN,    // next load strobe may program X and Y
    PRG_SECOND,  // next load strobe may reprogram Y only
    PRG_SHUT     // window closed until reset
  } prg_state_t;
endpackage

// File: rtl/sf_gray_sync.sv
module sf_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ stg[STAGES-1][i];
      bin_out[i] = acc;
    end
  end
endmodule

// File: rtl/sf_ram.sv
module sf_ram #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with enable: this register is the head-word holder
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sf_load_ctl.sv
module sf_load_ctl
  import strobe_fifo_pkg::*;
#(
  parameter int AW      = 8,
  parameter int OW      = 7,
  parameter int DEF_OFS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic          prog_n,
  input  logic [OW-1:0] ofs_in,
  input  logic [AW:0]   pop_bin,
  output logic          wr_go,
  output logic [AW:0]   wr_ptr,
  output logic [AW:0]   wr_gray,
  output logic          full_n,
  output logic          half_full,
  output logic          near_full,
  output logic [OW-1:0] ofs_x,
  output logic          prog_done
);
  localparam logic [AW:0] FULL_LVL = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HALF_LVL = {2'b01, {(AW-1){1'b0}}};

  prg_state_t    st;
  logic          prog_edge;
  logic [OW-1:0] ofs_y;
  logic [AW:0]   wr_nx;
  logic [AW:0]   fill_nx;
  logic [AW:0]   af_lvl;

  assign prog_edge = ld_en && !prog_n && (st != PRG_SHUT);
  assign wr_go     = ld_en && !prog_edge && full_n;
  assign wr_nx     = wr_ptr + {{AW{1'b0}}, wr_go};
  assign fill_nx   = wr_nx - pop_bin;
  assign af_lvl    = FULL_LVL - {{(AW+1-OW){1'b0}}, ofs_y};
  assign prog_done = (st == PRG_SHUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      wr_gray   <= '0;
      full_n    <= 1'b1;
      half_full <= 1'b0;
      near_full <= 1'b0;
      ofs_x     <= OW'(DEF_OFS);
      ofs_y     <= OW'(DEF_OFS);
      st        <= PRG_OPEN;
    end else begin
      wr_ptr    <= wr_nx;
      wr_gray   <= wr_nx ^ (wr_nx >> 1);
      full_n    <= (fill_nx != FULL_LVL);
      half_full <= (fill_nx >= HALF_LVL);
      near_full <= (fill_nx >= af_lvl);
      if (ld_en) begin
        case (st)
          PRG_OPEN: begin
            if (!prog_n) begin
              ofs_x <= ofs_in;
              ofs_y <= ofs_in;
              st    <= PRG_SECOND;
            end else begin
              st <= PRG_SHUT;
            end
          end
          PRG_SECOND: begin
            if (!prog_n) ofs_y <= ofs_in;
            st <= PRG_SHUT;
          end
          default: st <= PRG_SHUT;
        endcase
      end
    end
  end
endmodule

// File: rtl/sf_unload_ctl.sv
module sf_unload_ctl #(
  parameter int AW = 8,
  parameter int OW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ul_en,
  input  logic [AW:0]   wr_bin,
  input  logic [OW-1:0] ofs_x,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   pop_ptr,
  output logic [AW:0]   pop_gray,
  output logic          empty_n,
  output logic          near_empty
);
  logic [AW:0] fetch_ptr;
  logic [AW:0] fetch_nx;
  logic [AW:0] pop_nx;
  logic [AW:0] occ_nx;
  logic        pop;
  logic        avail;
  logic        head_nx;

  // empty_n doubles as "head register holds a valid word"
  assign pop      = ul_en && empty_n;
  assign avail    = (wr_bin != fetch_ptr);
  assign re       = avail && (!empty_n || pop);
  assign fetch_nx = fetch_ptr + {{AW{1'b0}}, re};
  assign pop_nx   = pop_ptr + {{AW{1'b0}}, pop};
  assign head_nx  = re || (empty_n && !pop);
  assign occ_nx   = wr_bin - pop_nx;
  assign raddr    = fetch_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_ptr  <= '0;
      pop_ptr    <= '0;
      pop_gray   <= '0;
      empty_n    <= 1'b0;
      near_empty <= 1'b1;
    end else begin
      fetch_ptr  <= fetch_nx;
      pop_ptr    <= pop_nx;
      pop_gray   <= pop_nx ^ (pop_nx >> 1);
      empty_n    <= head_nx;
      near_empty <= (occ_nx <= {{(AW+1-OW){1'b0}}, ofs_x});
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int DW          = 18,
  parameter int AW          = 8,
  parameter int OW          = 7,
  parameter int DEF_OFS     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_ld,
  input  logic          clk_ul,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [DW-1:0] din,
  input  logic          prog_n,
  input  logic          ul_en,
  input  logic          oe_n,
  output logic [DW-1:0] q,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          almost
);
  localparam int PW = AW + 1;

  logic          wr_go;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] wr_gray;
  logic [PW-1:0] wr_bin_ul;
  logic [PW-1:0] pop_ptr;
  logic [PW-1:0] pop_gray;
  logic [PW-1:0] pop_bin_ld;
  logic [OW-1:0] ofs_x;
  logic          prog_done;
  logic          near_full;
  logic          near_empty;
  logic          re;
  logic [AW-1:0] raddr;
  logic [DW-1:0] head;

  sf_load_ctl #(.AW(AW), .OW(OW), .DEF_OFS(DEF_OFS)) u_ld (
    .clk(clk_ld), .rst(rst), .ld_en(ld_en), .prog_n(prog_n),
    .ofs_in(din[OW-1:0]), .pop_bin(pop_bin_ld), .wr_go(wr_go),
    .wr_ptr(wr_ptr), .wr_gray(wr_gray), .full_n(full_n),
    .half_full(half_full), .near_full(near_full), .ofs_x(ofs_x),
    .prog_done(prog_done)
  );

  sf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk_ul), .rst(rst), .gray_in(wr_gray), .bin_out(wr_bin_ul)
  );

  sf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_psync (
    .clk(clk_ld), .rst(rst), .gray_in(pop_gray), .bin_out(pop_bin_ld)
  );

  sf_unload_ctl #(.AW(AW), .OW(OW)) u_ul (
    .clk(clk_ul), .rst(rst), .ul_en(ul_en), .wr_bin(wr_bin_ul),
    .ofs_x(ofs_x), .re(re), .raddr(raddr), .pop_ptr(pop_ptr),
    .pop_gray(pop_gray), .empty_n(empty_n), .near_empty(near_empty)
  );

  sf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(clk_ld), .we(wr_go), .waddr(wr_ptr[AW-1:0]), .wdata(din),
    .rclk(clk_ul), .re(re), .raddr(raddr), .rdata(head)
  );

  assign almost = near_empty | near_full;
  assign q      = oe_n ? {DW{1'bz}} : head;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int AW = 8
) (
  input logic        clk_ld,
  input logic        clk_ul,
  input logic        rst,
  input logic        ld_en,
  input logic        prog_n,
  input logic        ul_en,
  input logic        full_n,
  input logic        empty_n,
  input logic        half_full,
  input logic        almost,
  input logic        prog_done,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] pop_ptr
);
  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

  // R1
  occupancy_cap_chk: assert property (@(posedge clk_ld) disable iff (rst)
    (wr_ptr - pop_ptr) <= CAP);

  // R2
  full_load_ignored_chk: assert property (@(posedge clk_ld) disable iff (rst)
    (!full_n && ld_en) |=> $stable(wr_ptr));

  // R2
  empty_unload_ignored_chk: assert property (@(posedge clk_ul) disable iff (rst)
    (!empty_n && ul_en) |=> $stable(pop_ptr));

  // R4
  full_implies_half_chk: assert property (@(posedge clk_ld) disable iff (rst)
    !full_n |-> half_full);

  // R5
  full_implies_almost_chk: assert property (@(posedge clk_ld) disable iff (rst)
    !full_n |-> almost);

  // R5
  empty_implies_almost_chk: assert property (@(posedge clk_ul) disable iff (rst)
    !empty_n |-> almost);

  // R9
  prog_strobe_no_write_chk: assert property (@(posedge clk_ld) disable iff (rst)
    (ld_en && !prog_n && !prog_done) |=> $stable(wr_ptr));

  // R10
  window_stays_shut_chk: assert property (@(posedge clk_ld) disable iff (rst)
    prog_done |=> prog_done);
endmodule

bind strobe_fifo strobe_fifo_chk #(.AW(AW)) u_chk (
  .clk_ld(clk_ld), .clk_ul(clk_ul), .rst(rst), .ld_en(ld_en),
  .prog_n(prog_n), .ul_en(ul_en), .full_n(full_n), .empty_n(empty_n),
  .half_full(half_full), .almost(almost), .prog_done(prog_done),
  .wr_ptr(wr_ptr), .pop_ptr(pop_ptr)
);

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [17:0] din = '0;
  logic        prog_n = 1'b1;
  logic        ul_en = 1'b0;
  logic        oe_n = 1'b0;
  wire  [17:0] q_bus;
  logic        full_n, empty_n, half_full, almost;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  for (genvar i = 0; i < 18; i++) begin : g_pu
    pullup pu (q_bus[i]);
  end

  strobe_fifo u0 (
    .clk_ld(clk), .clk_ul(clk), .rst(rst), .ld_en(ld_en), .din(din),
    .prog_n(prog_n), .ul_en(ul_en), .oe_n(oe_n), .q(q_bus),
    .full_n(full_n), .empty_n(empty_n), .half_full(half_full),
    .almost(almost)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; ld_en = 1'b0; ul_en = 1'b0; prog_n = 1'b1; oe_n = 1'b0;
    repeat (4) step();
    rst = 1'b0;
    step();
  endtask

  task automatic load(input logic [17:0] w);
    din = w; ld_en = 1'b1;
    step();
    ld_en = 1'b0;
  endtask

  task automatic unload();
    ul_en = 1'b1;
    step();
    ul_en = 1'b0;
  endtask

  function automatic logic [17:0] pat(input int i);
    return 18'(i * 3 + 7);
  endfunction

  task automatic t_reset();
    do_reset();
    check("R6 full_n", 32'(full_n), 1);
    check("R6 empty_n", 32'(empty_n), 0);
    check("R6 half_full", 32'(half_full), 0);
    check("R6 almost", 32'(almost), 1);
  endtask

  task automatic t_fwft_oe();
    do_reset();
    load(18'h1A5A5);
    settle();
    check("R3 first word raises empty_n", 32'(empty_n), 1);
    check("R3 R11 head shown non-inverted", 32'(q_bus), 32'h1A5A5);
    check("R7 one word below default X", 32'(almost), 1);
    oe_n = 1'b1;
    step();
    check("R11 high impedance reads pulled", 32'(q_bus), 32'h3FFFF);
    oe_n = 1'b0;
    load(18'h00F0F);
    settle();
    check("R3 head holds without unload", 32'(q_bus), 32'h1A5A5);
    unload();
    check("R3 unload advances", 32'(q_bus), 32'h00F0F);
    unload();
    check("R12 empty_n sets on unload edge", 32'(empty_n), 0);
    unload();  // on empty
    load(18'h2C3C3);
    settle();
    check("R2 empty unload ignored", 32'(q_bus), 32'h2C3C3);
    unload();
    settle();
    check("R2 R3 drained", 32'(empty_n), 0);
  endtask

  task automatic t_fill_default();
    do_reset();
    for (int n = 1; n <= 256; n++) begin
      load(pat(n - 1));
      if (n == 256) check("R1 R12 full_n on 256th load", 32'(full_n), 0);
      if (n == 255) check("R1 not full at 255", 32'(full_n), 1);
      if (n == 32 || n == 33 || n == 223 || n == 224 || n == 127 || n == 128) begin
        settle();
        if (n == 32)  check("R7 R5 almost at 32", 32'(almost), 1);
        if (n == 33)  check("R7 R5 almost at 33", 32'(almost), 0);
        if (n == 223) check("R7 R5 almost at 223", 32'(almost), 0);
        if (n == 224) check("R7 R5 almost at 224", 32'(almost), 1);
        if (n == 127) check("R4 half_full at 127", 32'(half_full), 0);
        if (n == 128) check("R4 half_full at 128", 32'(half_full), 1);
      end
    end
    load(18'h3FFFF);  // while full
    settle();
    check("R2 still full", 32'(full_n), 0);
    for (int i = 0; i < 256; i++) begin
      check("R3 order", 32'(q_bus), 32'(pat(i)));
      unload();
    end
    check("R12 empty_n on last unload", 32'(empty_n), 0);
    settle();
    check("R2 load when full not stored", 32'(empty_n), 0);
    check("R1 full released", 32'(full_n), 1);
  endtask

  task automatic t_prog_two();
    do_reset();
    prog_n = 1'b0;
    load(18'h00005);
    load(18'h0000A);
    prog_n = 1'b1;
    settle();
    check("R9 programming stored nothing", 32'(empty_n), 0);
    for (int n = 1; n <= 246; n++) begin
      load(pat(n + 100));
      if (n == 1 || n == 5 || n == 6 || n == 245 || n == 246) begin
        settle();
        if (n == 1)   check("R9 first real word", 32'(q_bus), 32'(pat(101)));
        if (n == 5)   check("R8 almost at X=5", 32'(almost), 1);
        if (n == 6)   check("R8 almost at 6", 32'(almost), 0);
        if (n == 245) check("R8 almost at 245", 32'(almost), 0);
        if (n == 246) check("R8 almost at 256-Y=246", 32'(almost), 1);
      end
    end
  endtask

  task automatic t_prog_one_close();
    do_reset();
    prog_n = 1'b0;
    load(18'h00003);      // X = Y = 3
    prog_n = 1'b1;
    load(18'h11111);      // closes window, stored
    prog_n = 1'b0;
    load(18'h22214);      // window shut: ordinary write, low bits 20
    prog_n = 1'b1;
    settle();
    check("R10 head after close", 32'(q_bus), 32'h11111);
    check("R8 two words at X=3", 32'(almost), 1);
    load(18'h00001);
    load(18'h00002);
    settle();
    check("R10 X unchanged by late strobe", 32'(almost), 0);
    unload();
    check("R10 late strobe word stored", 32'(q_bus), 32'h22214);
  endtask

  initial begin
    t_reset();
    t_fwft_oe();
    t_fill_default();
    t_prog_two();
    t_prog_one_close();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule